// File: doc/BRIEF.md
# Three-Wire Tuning Word Receiver

This block receives tuning words for a frequency synthesizer over a three-wire serial link made of an enable line, a serial clock and a serial data line. While the enable line is high, each rising edge of the serial clock shifts one data bit into a frame buffer, most significant bit first, and a counter records how many bits arrived. When the enable line falls, the length of the frame determines the format. The decoded fields are then written into the band-switch, divider and control registers that drive the synthesizer core.

Two short formats carry a four-bit band-switch word followed by a 14-bit or 15-bit divider value. A long 27-bit format adds a control field for the pump current, the reference ratio select pair and the three test bits. Frames of any other length are dropped and reported with a one-cycle error strobe. A band-switch word that would turn on more than two outputs is refused, and the band register keeps its previous value. The whole receiver listens only while the bus-select input is high. All three serial inputs and the bus select are resynchronised to the system clock, so the link may run at any rate well below a quarter of the clock rate.

Top module: `tuneword_rx`

## Requirements
- R1: After a synchronous reset, band_sw is 0, div_n is 0, pump_hi is 1, ratio_a and ratio_b are 0, test_mode is 3'b001, and frame_err is 0.
- R2: A data bit is taken on each rising edge of scl while ce is high, and the first bit received is the most significant bit of the frame. The value of sda at a falling edge of scl has no effect.
- R3: While a frame is being received, the register outputs keep their previous values. They change only after ce falls.
- R4: An 18-bit frame is read as band_sw[3:0] followed by 14 divider bits. div_n[13:0] takes those 14 bits, and div_n[14] is cleared.
- R5: A 19-bit frame is read as band_sw[3:0] followed by div_n[14:0].
- R6: A 27-bit frame is read as band_sw[3:0], then div_n[14:0], then pump_hi, then test_mode[2:0], then ratio_a, then ratio_b, then two bits that are ignored.
- R7: A frame whose length is not 18, 19 or 27 bits (longer frames included) leaves every register unchanged and raises frame_err for exactly one clock cycle.
- R8: A band-switch field with more than two bits set is refused, and band_sw keeps its old value. The other fields of the same frame are still written. band_sw never has more than two bits set.
- R9: While bus_sel is low, every serial activity is ignored. A frame during which bus_sel goes low is dropped without an error, even after bus_sel returns high.
- R10: An 18-bit or 19-bit frame leaves pump_hi, ratio_a, ratio_b and test_mode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | High selects the three-wire receiver |
| ce | input | 1 | Frame enable; a frame is framed by its high period |
| scl | input | 1 | Serial bit clock |
| sda | input | 1 | Serial data |
| band_sw | output | 4 | Band-switch output enables |
| div_n | output | 15 | Programmable divider value |
| pump_hi | output | 1 | High selects the high pump current |
| ratio_a | output | 1 | Reference ratio select bit A |
| ratio_b | output | 1 | Reference ratio select bit B |
| test_mode | output | 3 | Test bit field |
| frame_err | output | 1 | One-cycle strobe for a frame of invalid length |

## Verification
The bench changes sda together with each falling edge of scl. A receiver that samples on the wrong edge therefore loads shifted data and fails every field comparison. An 18-bit frame follows a frame with the top divider bit set, so a design that keeps div_n[14] or takes the wrong slice is caught. Short frames follow a long frame with non-default control bits, which exposes any writes to the control fields. Lengths of 5, 20, 26 and 30 bits check that nothing is written and that the error strobe is exactly one cycle wide. A frame that is left without changes when an update is due would show up as a stale register. Band words with three and four bits set must keep the old band but still change the divider. A frame sent with bus_sel low, and a frame cut short by bus_sel falling, must change nothing and raise no error.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int BAND_W      = 4;
  localparam int DIV_W       = 15;
  localparam int TEST_W      = 3;
  localparam int CTRL_W      = 8;
  localparam int LEN_SHORT   = 18;
  localparam int LEN_MID     = 19;
  localparam int LEN_LONG    = BAND_W + DIV_W + CTRL_W;
  localparam int MAX_BAND_ON = 2;

  typedef struct packed {
    logic [BAND_W-1:0] band;
    logic [DIV_W-1:0]  div;
    logic              pump;
    logic              ratio_a;
    logic              ratio_b;
    logic [TEST_W-1:0] test;
  } tw_regs_t;

  localparam tw_regs_t REGS_RST = '{
    band:    '0,
    div:     '0,
    pump:    1'b1,
    ratio_a: 1'b0,
    ratio_b: 1'b0,
    test:    TEST_W'(1)
  };
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tw_shift.sv
module tw_shift #(
  parameter int MAX_LEN = 27,
  parameter int CNT_W   = $clog2(MAX_LEN + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               ce_s,
  input  logic               scl_s,
  input  logic               sda_s,
  output logic [MAX_LEN-1:0] word,
  output logic [CNT_W-1:0]   cnt,
  output logic               frame_end
);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  logic ce_q, scl_q;
  logic ce_rise, ce_fall, scl_rise;

  assign ce_rise  = ce_s & ~ce_q;
  assign ce_fall  = ~ce_s & ce_q;
  assign scl_rise = scl_s & ~scl_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ce_q      <= 1'b0;
      scl_q     <= 1'b0;
      word      <= '0;
      cnt       <= '0;
      frame_end <= 1'b0;
    end else begin
      ce_q      <= ce_s;
      scl_q     <= scl_s;
      frame_end <= ce_fall;
      if (ce_rise) begin
        word <= '0;
        cnt  <= '0;
      end else if (ce_s && scl_rise) begin
        word <= {word[MAX_LEN-2:0], sda_s};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tw_decode.sv
module tw_decode
  import tw_pkg::*;
#(
  parameter int MAX_LEN = LEN_LONG,
  parameter int CNT_W   = $clog2(MAX_LEN + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               frame_end,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [MAX_LEN-1:0] word,
  output tw_regs_t           regs,
  output logic               frame_err
);
  localparam int SHORT_DIV_W = LEN_SHORT - BAND_W;
  localparam int CTRL_LSB    = LEN_LONG - BAND_W - DIV_W - CTRL_W;
  localparam int PUMP_POS    = CTRL_LSB + CTRL_W - 1;
  localparam int TEST_MSB    = PUMP_POS - 1;
  localparam int RA_POS      = TEST_MSB - TEST_W;
  localparam int RB_POS      = RA_POS - 1;

  function automatic int ones(input logic [BAND_W-1:0] v);
    int n = 0;
    for (int i = 0; i < BAND_W; i++) n += int'(v[i]);
    return n;
  endfunction

  tw_regs_t          nxt;
  logic              valid;
  logic [BAND_W-1:0] band_in;

  always_comb begin
    nxt     = regs;
    valid   = 1'b1;
    band_in = regs.band;
    if (cnt == CNT_W'(LEN_SHORT)) begin
      band_in = word[LEN_SHORT-1 -: BAND_W];
      nxt.div = DIV_W'(word[SHORT_DIV_W-1:0]);
    end else if (cnt == CNT_W'(LEN_MID)) begin
      band_in = word[LEN_MID-1 -: BAND_W];
      nxt.div = word[DIV_W-1:0];
    end else if (cnt == CNT_W'(LEN_LONG)) begin
      band_in     = word[LEN_LONG-1 -: BAND_W];
      nxt.div     = word[LEN_LONG-BAND_W-1 -: DIV_W];
      nxt.pump    = word[PUMP_POS];
      nxt.test    = word[TEST_MSB -: TEST_W];
      nxt.ratio_a = word[RA_POS];
      nxt.ratio_b = word[RB_POS];
    end else begin
      valid = 1'b0;
    end
    if (ones(band_in) <= MAX_BAND_ON) nxt.band = band_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regs      <= REGS_RST;
      frame_err <= 1'b0;
    end else begin
      frame_err <= 1'b0;
      if (frame_end && en) begin
        if (valid) regs      <= nxt;
        else       frame_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tuneword_rx.sv
module tuneword_rx
  import tw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              ce,
  input  logic              scl,
  input  logic              sda,
  output logic [BAND_W-1:0] band_sw,
  output logic [DIV_W-1:0]  div_n,
  output logic              pump_hi,
  output logic              ratio_a,
  output logic              ratio_b,
  output logic [TEST_W-1:0] test_mode,
  output logic              frame_err
);
  localparam int MAX_LEN = LEN_LONG;
  localparam int CNT_W   = $clog2(MAX_LEN + 2);

  logic [3:0]         pins_s;
  logic               sel_q, ce_s, scl_s, sda_s;
  logic [MAX_LEN-1:0] word;
  logic [CNT_W-1:0]   cnt;
  logic               frame_end;
  tw_regs_t           regs;

  tw_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({bus_sel, ce, scl, sda}),
    .q(pins_s)
  );

  assign {sel_q, ce_s, scl_s, sda_s} = pins_s;

  tw_shift #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .en(sel_q),
    .ce_s(ce_s), .scl_s(scl_s), .sda_s(sda_s),
    .word(word), .cnt(cnt), .frame_end(frame_end)
  );

  tw_decode #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_decode (
    .clk(clk), .rst(rst), .en(sel_q),
    .frame_end(frame_end), .cnt(cnt), .word(word),
    .regs(regs), .frame_err(frame_err)
  );

  assign band_sw   = regs.band;
  assign div_n     = regs.div;
  assign pump_hi   = regs.pump;
  assign ratio_a   = regs.ratio_a;
  assign ratio_b   = regs.ratio_b;
  assign test_mode = regs.test;
endmodule

// File: rtl/tw_checks.sv
module tw_checks
  import tw_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              sel_q,
  input logic [BAND_W-1:0] band_sw,
  input logic [DIV_W-1:0]  div_n,
  input logic              pump_hi,
  input logic [TEST_W-1:0] test_mode,
  input logic              frame_err
);
  p_reset_vals_r1: assert property (@(posedge clk)
    rst |=> (band_sw == '0 && div_n == '0 && pump_hi && test_mode == TEST_W'(1) && !frame_err));

  p_err_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> !frame_err);

  p_err_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> ($stable(div_n) && $stable(band_sw) && $stable(pump_hi) && $stable(test_mode)));

  p_band_limit_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(band_sw) <= MAX_BAND_ON);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !sel_q |=> ($stable(div_n) && $stable(band_sw) && $stable(test_mode) && !frame_err));
endmodule

bind tuneword_rx tw_checks u_checks (
  .clk(clk), .rst(rst), .sel_q(sel_q), .band_sw(band_sw), .div_n(div_n),
  .pump_hi(pump_hi), .test_mode(test_mode), .frame_err(frame_err)
);

// File: tb/tuneword_rx_test.sv
module tuneword_rx_test;
  import tw_pkg::*;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst = 1'b1, bus_sel = 1'b1, ce = 1'b0, scl = 1'b0, sda = 1'b0;
  logic [3:0]  band_sw;
  logic [14:0] div_n;
  logic        pump_hi, ratio_a, ratio_b, frame_err;
  logic [2:0]  test_mode;

  tuneword_rx uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .ce(ce), .scl(scl), .sda(sda),
    .band_sw(band_sw), .div_n(div_n), .pump_hi(pump_hi), .ratio_a(ratio_a),
    .ratio_b(ratio_b), .test_mode(test_mode), .frame_err(frame_err)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    logic [3:0] band; logic [14:0] div; logic pump, ra, rb; logic [2:0] test;
    int errs; string tag;
  } exp_t;

  exp_t q[$];
  int   tests = 0, fails = 0, errs_seen = 0, errs_exp = 0;
  bit   done = 1'b0;
  event chk_ev;

  logic [3:0]  m_band = '0;
  logic [14:0] m_div = '0;
  logic        m_pump = 1'b1, m_ra = 1'b0, m_rb = 1'b0;
  logic [2:0]  m_test = 3'b001;

  always @(negedge clk) if (!rst && frame_err) errs_seen++;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(chk_ev);
      begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "band_sw", 32'(band_sw), 32'(e.band));
        check(e.tag, "div_n", 32'(div_n), 32'(e.div));
        check(e.tag, "pump_hi", 32'(pump_hi), 32'(e.pump));
        check(e.tag, "ratio_a", 32'(ratio_a), 32'(e.ra));
        check(e.tag, "ratio_b", 32'(ratio_b), 32'(e.rb));
        check(e.tag, "test_mode", 32'(test_mode), 32'(e.test));
        check(e.tag, "error strobes", 32'(errs_seen), 32'(e.errs));
      end
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // drop_at >= 0 pulls bus_sel low at that bit index (R9)
  task automatic send(logic [31:0] bits, int n, int drop_at, string tag);
    sda = bits[n-1];
    ce  = 1'b1;
    wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      if (i == drop_at) bus_sel = 1'b0;
      scl = 1'b1;
      wait_clk(4);
      scl = 1'b0;
      sda = (i > 0) ? bits[i-1] : ~bits[0];  // data moves with the falling edge (R2)
      wait_clk(4);
      if (i == n / 2) begin
        check({tag, " R3"}, "mid-frame div_n", 32'(div_n), 32'(m_div));
        check({tag, " R3"}, "mid-frame band_sw", 32'(band_sw), 32'(m_band));
      end
    end
    ce = 1'b0;
    wait_clk(10);
  endtask

  function automatic int ones4(logic [3:0] v);
    return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
  endfunction

  task automatic push_exp(string tag);
    exp_t e;
    e.band = m_band; e.div = m_div; e.pump = m_pump; e.ra = m_ra; e.rb = m_rb;
    e.test = m_test; e.errs = errs_exp; e.tag = tag;
    q.push_back(e);
    -> chk_ev;
    wait_clk(1);
  endtask

  task automatic frame(logic [31:0] bits, int n, string tag);
    logic [3:0] b;
    send(bits, n, -1, tag);
    b = 4'h0;
    if (n == 18) begin
      b = bits[17:14]; m_div = {1'b0, bits[13:0]};
    end else if (n == 19) begin
      b = bits[18:15]; m_div = bits[14:0];
    end else if (n == 27) begin
      b = bits[26:23]; m_div = bits[22:8];
      m_pump = bits[7]; m_test = bits[6:4]; m_ra = bits[3]; m_rb = bits[2];
    end else begin
      errs_exp++;
    end
    if ((n == 18 || n == 19 || n == 27) && ones4(b) <= 2) m_band = b;
    push_exp(tag);
  endtask

  initial begin
    wait_clk(3);
    rst = 1'b0;
    wait_clk(1);
    check("R1", "band_sw", 32'(band_sw), 32'h0);
    check("R1", "div_n", 32'(div_n), 32'h0);
    check("R1", "pump_hi", 32'(pump_hi), 32'h1);
    check("R1", "ratio_a", 32'(ratio_a), 32'h0);
    check("R1", "ratio_b", 32'(ratio_b), 32'h0);
    check("R1", "test_mode", 32'(test_mode), 32'h1);
    check("R1", "frame_err", 32'(frame_err), 32'h0);

    frame({13'h0, 4'b0101, 15'h5A3C}, 19, "R5 R2 19-bit");
    frame({14'h0, 4'b0010, 14'h2BCD}, 18, "R4 18-bit clears top");
    frame({5'h0, 4'b1000, 15'h1234, 8'b0110_1011}, 27, "R6 27-bit");
    frame({14'h0, 4'b0001, 14'h0F0F}, 18, "R10 18-bit keeps ctrl");
    frame({13'h0, 4'b0100, 15'h7001}, 19, "R10 19-bit keeps ctrl");
    frame({5'h0, 4'b0011, 15'h4321, 8'b1001_0111}, 27, "R6 27-bit second");
    frame(32'hFFFFF, 20, "R7 20-bit");
    frame(32'h15, 5, "R7 5-bit");
    frame(32'h3FFFFFF, 26, "R7 26-bit");
    frame(32'h2AAAAAAA, 30, "R7 30-bit");
    frame({13'h0, 4'b0111, 15'h0ABC}, 19, "R8 three bands");
    frame({5'h0, 4'b1111, 15'h7EDC, 8'b0000_1100}, 27, "R8 four bands");
    frame({13'h0, 4'b1001, 15'h2222}, 19, "R8 two bands");

    bus_sel = 1'b0;
    wait_clk(4);
    send({13'h0, 4'b0100, 15'h1111}, 19, -1, "R9 deselected");
    bus_sel = 1'b1;
    wait_clk(4);
    push_exp("R9 deselected");

    send({13'h0, 4'b0010, 15'h3333}, 19, 5, "R9 dropped");
    bus_sel = 1'b1;
    wait_clk(4);
    push_exp("R9 dropped");

    frame({13'h0, 4'b0000, 15'h0001}, 19, "R5 after reselect");

    wait_clk(4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule